// File: doc/BRIEF.md
# External Bus Strobe Timer

This block times the control strobes of one external memory region for a single bus cycle. A start pulse launches a cycle. From then on a counter advances once per memory clock, and the address strobe, read enable and write enable go active (low) and inactive at counts taken from a configuration word. The configuration word and the read/write select are captured when the cycle starts, so later changes to them do not affect a cycle already running. A one-clock done pulse marks the last count of the cycle. The block then returns to idle with every strobe released.

The configuration word is read in one of two ways, chosen by its mode bit. In fixed-wait mode the cycle length is set entirely by the fields. In handshaking mode the counter stops at the read/write-enable assert point until an acknowledge input is sampled high. It then holds there for a programmed number of extra clocks before it continues. The block checks the configuration all the time. A prohibited code, a broken ordering rule, or handshaking at a clock ratio other than four raises an error flag, and start pulses are refused while the flag is set.

Top module: `ext_strobe_timer`

## Requirements
- R1: After reset the block is idle: asN, reN and weN are 1, and addrValid and cycleDone are 0.
- R2: Bit 0 of cfgWord selects handshaking mode when 1. Bit 1 drives asyncMode and bit 2 drives wide16 (1 means a 16-bit bus), both directly from the current cfgWord.
- R3: Fixed-wait field layout: asOn = cfgWord[4:3], asOff = cfgWord[7:5], strbOff = cfgWord[12:8]. At cycle count n, asN is low when asOn <= n < asOff. The selected read or write strobe is low when asOn <= n < strbOff. addrValid is 1 when n < asOff. The last count is strbOff.
- R4: A fixed-wait configuration is legal only when asOn != 0, asOff != 0, asOff > asOn, strbOff > asOn and strbOff >= asOff. Otherwise cfgErr is 1.
- R5: Handshaking field layout: ackWait = cfgWord[4:3], rwOn = cfgWord[6:5], addrEnd = cfgWord[8:7], strbOff = cfgWord[13:9], cycEnd = cfgWord[18:14]. asN is low and addrValid is 1 when n < addrEnd. The selected strobe is low when rwOn <= n < strbOff. The last count is cycEnd.
- R6: In handshaking mode the count holds at rwOn until ackIn is sampled 1 at a clock edge. It then holds for ackWait further clocks and resumes counting.
- R7: A handshaking configuration is legal only when rwOn != 0, strbOff > rwOn, strbOff >= addrEnd, cycEnd >= strbOff and clkRatio == 4. Otherwise cfgErr is 1. clkRatio is the memory-clock to system-clock ratio.
- R8: A start pulse while cfgErr is 1 is ignored: the outputs stay idle.
- R9: cycleDone is 1 for exactly the clock whose count equals the last count. On the next clock all outputs are idle again.
- R10: A cycle drives reN only when isWrite was 0 at start and weN only when it was 1. The two are never low together.
- R11: A start pulse or a change of isWrite during a running cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a bus cycle |
| isWrite | input | 1 | 1 selects a write cycle |
| cfgWord | input | 19 | Mode bits and timing fields |
| clkRatio | input | 3 | Memory clock to system clock ratio |
| ackIn | input | 1 | External acknowledge, active high |
| asN | output | 1 | Address strobe, active low |
| reN | output | 1 | Read enable, active low |
| weN | output | 1 | Write enable, active low |
| wide16 | output | 1 | 16-bit bus selected |
| asyncMode | output | 1 | Memory-clock asynchronous mode selected |
| addrValid | output | 1 | Address output window |
| cycleDone | output | 1 | One-clock end-of-cycle pulse |
| cfgErr | output | 1 | Configuration is illegal |

## Verification
The bench uses the default 5-bit counter, which lets every fixed-wait field combination be swept in full: all asOn, asOff and strbOff codes, legal and illegal. For handshaking it sweeps every ackWait, rwOn and addrEnd code against strbOff up to 5 and cycEnd up to 7, with the acknowledge arriving either at once or one clock late. Each legal cycle is compared clock by clock against a count sequence the bench derives from the fields. Each illegal one is checked for the error flag and for the refused start.

// File: rtl/ext_strobe_timer_pkg.sv
package ext_strobe_timer_pkg;
  localparam int CFG_W = 19;

  // control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic running;
  } ctrlBus_t;

  // datapath to control
  typedef struct packed {
    logic       hsMode;
    logic       atAck;
    logic       atEnd;
    logic [1:0] ackWait;
  } dpStatus_t;
endpackage

// File: rtl/ext_strobe_cfg_check.sv
module ext_strobe_cfg_check
  import ext_strobe_timer_pkg::*;
#(
  parameter int RATIO_W = 3,
  parameter int HS_RATIO = 4
) (
  input  logic             hsSel,
  input  logic [CFG_W-1:3] fields,
  input  logic [RATIO_W-1:0] clkRatio,
  output logic             cfgErr
);
  logic [1:0] asOn, rwOn, addrEnd;
  logic [2:0] asOff;
  logic [4:0] fxOff, hsOff, cycEnd;
  logic fixedOk, hsOk;

  always_comb begin
    asOn    = fields[4:3];
    asOff   = fields[7:5];
    fxOff   = fields[12:8];
    rwOn    = fields[6:5];
    addrEnd = fields[8:7];
    hsOff   = fields[13:9];
    cycEnd  = fields[18:14];
    fixedOk = (asOn != 2'd0) && (asOff != 3'd0) && ({1'b0, asOff} > {2'b0, asOn})
              && (fxOff > {3'b0, asOn}) && (fxOff >= {2'b0, asOff});
    hsOk    = (rwOn != 2'd0) && (hsOff > {3'b0, rwOn}) && (hsOff >= {3'b0, addrEnd})
              && (cycEnd >= hsOff) && (clkRatio == RATIO_W'(HS_RATIO));
    cfgErr  = hsSel ? !hsOk : !fixedOk;
  end
endmodule

// File: rtl/ext_strobe_ctrl.sv
module ext_strobe_ctrl
  import ext_strobe_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      cfgErr,
  input  logic      ackIn,
  input  dpStatus_t status,
  output ctrlBus_t  ctrlBus,
  output logic      cycleDone
);
  typedef enum logic {IDLE, RUN} state_t;
  state_t     state;
  logic       ackSeen;
  logic [1:0] holdLeft;
  logic       waitingAck;

  always_comb begin
    waitingAck      = status.hsMode && status.atAck && !ackSeen;
    ctrlBus.running = (state == RUN);
    ctrlBus.load    = (state == IDLE) && startPulse && !cfgErr;
    cycleDone       = ctrlBus.running && status.atEnd;
    if (!ctrlBus.running || status.atEnd) ctrlBus.advance = 1'b0;
    else if (waitingAck)                   ctrlBus.advance = ackIn && (status.ackWait == 2'd0);
    else if (holdLeft > 2'd1)              ctrlBus.advance = 1'b0;
    else                                   ctrlBus.advance = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      ackSeen  <= 1'b0;
      holdLeft <= 2'd0;
    end else if (state == IDLE) begin
      if (ctrlBus.load) begin
        state    <= RUN;
        ackSeen  <= 1'b0;
        holdLeft <= 2'd0;
      end
    end else if (status.atEnd) begin
      state <= IDLE;
    end else if (waitingAck) begin
      if (ackIn) begin
        ackSeen  <= 1'b1;
        holdLeft <= status.ackWait;
      end
    end else if (holdLeft != 2'd0) begin
      holdLeft <= holdLeft - 2'd1;
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);
  assert_refuse_bad_cfg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == IDLE && startPulse && cfgErr) |=> (state == IDLE));
  assert_wait_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.running && waitingAck && !ackIn) |=> (state == RUN && !ackSeen));
endmodule

// File: rtl/ext_strobe_datapath.sv
module ext_strobe_datapath
  import ext_strobe_timer_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlBus_t         ctrlBus,
  input  logic             hsSel,
  input  logic [CFG_W-1:3] fields,
  input  logic             isWrite,
  output dpStatus_t        status,
  output logic             asN,
  output logic             reN,
  output logic             weN,
  output logic             addrValid
);
  logic             hsQ, wrQ;
  logic [CFG_W-1:3] fieldsQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] onVal, asStart, asStop, rwStop, endVal;
  logic             asAct, rwAct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsQ     <= 1'b0;
      wrQ     <= 1'b0;
      fieldsQ <= '0;
      cnt     <= '0;
    end else if (ctrlBus.load) begin
      hsQ     <= hsSel;
      wrQ     <= isWrite;
      fieldsQ <= fields;
      cnt     <= '0;
    end else if (ctrlBus.advance) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    if (hsQ) begin
      onVal   = CNT_W'(fieldsQ[6:5]);
      asStart = '0;
      asStop  = CNT_W'(fieldsQ[8:7]);
      rwStop  = CNT_W'(fieldsQ[13:9]);
      endVal  = CNT_W'(fieldsQ[18:14]);
    end else begin
      onVal   = CNT_W'(fieldsQ[4:3]);
      asStart = onVal;
      asStop  = CNT_W'(fieldsQ[7:5]);
      rwStop  = CNT_W'(fieldsQ[12:8]);
      endVal  = rwStop;
    end
    asAct          = ctrlBus.running && (cnt >= asStart) && (cnt < asStop);
    rwAct          = ctrlBus.running && (cnt >= onVal) && (cnt < rwStop);
    asN            = !asAct;
    reN            = !(rwAct && !wrQ);
    weN            = !(rwAct && wrQ);
    addrValid      = ctrlBus.running && (cnt < asStop);
    status.hsMode  = hsQ;
    status.atAck   = (cnt == onVal);
    status.atEnd   = (cnt == endVal);
    status.ackWait = fieldsQ[4:3];
  end

  assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(!reN && !weN));
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBus.load && !ctrlBus.advance) |=> $stable(cnt));
  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.running |-> (cnt <= endVal));
endmodule

// File: rtl/ext_strobe_timer.sv
module ext_strobe_timer
  import ext_strobe_timer_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               isWrite,
  input  logic [CFG_W-1:0]   cfgWord,
  input  logic [RATIO_W-1:0] clkRatio,
  input  logic               ackIn,
  output logic               asN,
  output logic               reN,
  output logic               weN,
  output logic               wide16,
  output logic               asyncMode,
  output logic               addrValid,
  output logic               cycleDone,
  output logic               cfgErr
);
  ctrlBus_t  ctrlBus;
  dpStatus_t status;

  assign wide16    = cfgWord[2];
  assign asyncMode = cfgWord[1];

  ext_strobe_cfg_check #(.RATIO_W(RATIO_W), .HS_RATIO(4)) u_check (
    .hsSel(cfgWord[0]), .fields(cfgWord[CFG_W-1:3]), .clkRatio(clkRatio), .cfgErr(cfgErr));

  ext_strobe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cfgErr(cfgErr), .ackIn(ackIn),
    .status(status), .ctrlBus(ctrlBus), .cycleDone(cycleDone));

  ext_strobe_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .hsSel(cfgWord[0]),
    .fields(cfgWord[CFG_W-1:3]), .isWrite(isWrite), .status(status),
    .asN(asN), .reN(reN), .weN(weN), .addrValid(addrValid));
endmodule

// File: tb/ext_strobe_timer_bench.sv
`timescale 1ns/1ps
module ext_strobe_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        isWrite = 1'b0;
  logic [18:0] cfgWord = '0;
  logic [2:0]  clkRatio = 3'd4;
  logic        ackIn = 1'b0;
  logic asN, reN, weN, wide16, asyncMode, addrValid, cycleDone, cfgErr;
  int nRun = 0;
  int nFail = 0;
  localparam logic [4:0] IDLE_V = 5'b11100;

  always #2.5 clk = ~clk;

  ext_strobe_timer u_ext_strobe_timer (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .isWrite(isWrite), .cfgWord(cfgWord),
    .clkRatio(clkRatio), .ackIn(ackIn), .asN(asN), .reN(reN), .weN(weN), .wide16(wide16),
    .asyncMode(asyncMode), .addrValid(addrValid), .cycleDone(cycleDone), .cfgErr(cfgErr));

  function automatic logic [4:0] outVec();
    return {asN, reN, weN, addrValid, cycleDone};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h cfg=%0h", req, act, exp, cfgWord);
    end
  endtask

  function automatic logic [4:0] expVec(logic [18:0] c, bit wr, int n, bit done);
    bit asAct, rwAct, av;
    if (c[0]) begin
      asAct = n < int'(c[8:7]);
      rwAct = n >= int'(c[6:5]) && n < int'(c[13:9]);
      av    = asAct;
    end else begin
      asAct = n >= int'(c[4:3]) && n < int'(c[7:5]);
      rwAct = n >= int'(c[4:3]) && n < int'(c[12:8]);
      av    = n < int'(c[7:5]);
    end
    return {!asAct, !(rwAct && !wr), !(rwAct && wr), av, done};
  endfunction

  // legal cycle: compare every clock against the derived count sequence
  task automatic runCycle(input logic [18:0] c, input bit wr, input int delay, input string req);
    int rw, hold, last, n;
    rw   = c[0] ? int'(c[6:5]) : 0;
    hold = rw + delay + int'(c[4:3]);
    last = c[0] ? hold + int'(c[18:14]) - rw : int'(c[12:8]);
    @(negedge clk);
    cfgWord = c; isWrite = wr; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int j = 0; j <= last; j++) begin
      if (c[0]) n = (j <= hold) ? ((j < rw) ? j : rw) : rw + (j - hold);
      else      n = j;
      chk(req, outVec(), expVec(c, wr, n, j == last));
      startPulse = (j == 1);            // R11 restart attempt mid-cycle
      isWrite    = (j == 1) ? !wr : wr; // R11 select change mid-cycle
      ackIn      = c[0] && (j == rw + delay);
      @(negedge clk);
    end
    startPulse = 1'b0; ackIn = 1'b0;
    chk("R9 idle after done", outVec(), IDLE_V);
  endtask

  task automatic refuse(input logic [18:0] c, input string req);
    @(negedge clk);
    cfgWord = c;
    #1 chk(req, cfgErr, 1);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R8 start refused", outVec(), IDLE_V);
    @(negedge clk);
    chk("R8 still idle", outVec(), IDLE_V);
  endtask

  initial begin
    #(5.0 * 190000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [18:0] c;
    bit ok;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", outVec(), IDLE_V);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", outVec(), IDLE_V);

    // R2 mode bits
    for (int m = 0; m < 4; m++) begin
      cfgWord = 19'(m << 1);
      #1 chk("R2 wide16", wide16, m >> 1);
      chk("R2 asyncMode", asyncMode, m & 1);
      @(negedge clk);
    end

    // fixed-wait sweep
    for (int on = 0; on < 4; on++)
      for (int off = 0; off < 8; off++)
        for (int so = 0; so < 32; so++) begin
          c = 19'((so << 8) | (off << 5) | (on << 3) | ((so & 3) << 1));
          ok = on != 0 && off != 0 && off > on && so > on && so >= off;
          if (ok) begin
            @(negedge clk); cfgWord = c;
            #1 chk("R4 legal fixed", cfgErr, 0);
            runCycle(c, so[0], 0, "R3 R10 R11 fixed cycle");
          end else refuse(c, "R4 illegal fixed");
        end

    // handshaking sweep
    for (int w = 0; w < 4; w++)
      for (int rw = 0; rw < 4; rw++)
        for (int ae = 0; ae < 4; ae++)
          for (int so = 0; so < 6; so++)
            for (int ce = 0; ce < 8; ce++) begin
              c = 19'((ce << 14) | (so << 9) | (ae << 7) | (rw << 5) | (w << 3) | 1);
              ok = rw != 0 && so > rw && so >= ae && ce >= so;
              if (ok) begin
                @(negedge clk); cfgWord = c;
                #1 chk("R7 legal handshake", cfgErr, 0);
                runCycle(c, ce[0], 0, "R5 R6 R10 handshake cycle");
                runCycle(c, !ce[0], 1, "R6 late ack cycle");
              end else refuse(c, "R7 illegal handshake");
            end

    // R7 clock ratio rule
    c = 19'((7 << 14) | (5 << 9) | (1 << 7) | (1 << 5) | 1);
    clkRatio = 3'd2;
    refuse(c, "R7 ratio 2");
    clkRatio = 3'd1;
    refuse(c, "R7 ratio 1");
    cfgWord = 19'((4 << 8) | (2 << 5) | (1 << 3));
    #1 chk("R4 fixed legal at ratio 1", cfgErr, 0);
    clkRatio = 3'd4;
    runCycle(c, 1'b0, 2, "R6 two-clock ack delay");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule